// File: doc/BRIEF.md
# OTP Fuse Array Read Sequencer

The block reads a run of consecutive 32-bit words out of a one-time-programmable fuse macro by driving the macro's pin-level controls itself. A request carries a byte offset and a byte length. The block first checks the request. If the request is valid, it brings the macro out of deep standby and gives one timed clock pulse per word. It hands each word to a valid/ready output stream and then puts the macro back to sleep.

All macro timing is given in nanoseconds through parameters and converted to system-clock cycles at elaboration. This covers the clock-high access phase, the clock-low phase and the spacing between power steps. A consumer that holds back the output stream stalls the sequencer, and the macro clock stays low for the whole stall. A request that fails a check produces a one-cycle error pulse and does not touch the macro.

Top module: `otp_read_seq`

## Requirements
- R1: A request whose byte offset or byte length has either of its two low bits set is refused: `err` is high for exactly the one cycle after acceptance, `busy` stays low and no macro pin leaves its idle level.
- R2: A request with start word (offset/4) at or above `FUSE_WORDS`, or with start word plus word count (length/4) above `FUSE_WORDS`, is refused in the same way as in R1.
- R3: Power-up for a valid request releases deep standby (`otp_stby_n` rises, together with `busy`). `otp_trim_en` rises STEP cycles later and `otp_ce` rises STEP cycles after that. The first macro clock rise comes STEP cycles after `otp_ce`.
- R4: For each word the address pins carry the word index, and `otp_clk` is high for exactly ACC cycles. The address does not change while `otp_clk` is high.
- R5: After each clock-high phase `otp_clk` stays low for LOW cycles, and the word is then presented. The presented word is the value the macro returned for that address.
- R6: Words leave in ascending address order, exactly length/4 of them. While `out_valid` is high and `out_ready` is low, `out_data` is held and `otp_clk` stays low.
- R7: Power-down runs in reverse after the last word: `otp_ce` falls, then `otp_trim_en` falls STEP cycles later, then `otp_stby_n` falls STEP cycles after that. `busy` falls STEP cycles after `otp_stby_n`.
- R8: `req_ready` is high only when `busy` is low. A request offered while busy is ignored: it gives no `err` and does not change the word stream.
- R9: A valid request of length zero runs the full power-up and power-down with no macro clock pulse and no output word.
- R10: At every cycle `otp_clk` high implies `otp_ce` high, `otp_ce` high implies `otp_trim_en` high, and `otp_trim_en` high implies `otp_stby_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_offset | input | OFFS_W | Start byte offset |
| req_len | input | LEN_W | Byte length |
| err | output | 1 | One-cycle pulse for a refused request |
| busy | output | 1 | High from standby release until power-down ends |
| out_valid | output | 1 | Read word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 32 | Read word |
| otp_stby_n | output | 1 | Macro deep-standby control, low = standby |
| otp_trim_en | output | 1 | Macro trim enable |
| otp_ce | output | 1 | Macro chip enable |
| otp_clk | output | 1 | Macro read clock |
| otp_addr | output | AW | Macro word address |
| otp_rdata | input | 32 | Macro read data |

## Verification
The bench sweeps every start word and every legal word count of a 16-word array. Each word holds a distinct computed value, so a wrong address, a skipped word or a repeated word shows up directly. The stall length changes from request to request. Zero stall checks back-to-back pulses. A longer stall checks data hold and that the clock stays low during the stall. Invalid requests are misaligned offsets, misaligned lengths, starts past the end and runs that overflow by one word. Each must give a bare error pulse, which separates the alignment check from the range check. A pin monitor times every power edge and every clock phase against the parameter cycle counts. One run also keeps a bad request pending while busy, to show that it is ignored.

// File: rtl/otp_rd_pkg.sv
package otp_rd_pkg;

    localparam int unsigned WORD_BITS  = 32;
    localparam int unsigned BYTE_SHIFT = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PU_STBY,
        ST_PU_TRIM,
        ST_PU_CE,
        ST_CLK_HI,
        ST_CLK_LO,
        ST_XFER,
        ST_PD_CE,
        ST_PD_TRIM,
        ST_PD_STBY
    } seq_state_e;

    // nanoseconds to whole cycles, rounded up, never below one
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
        int unsigned c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/otp_req_check.sv
module otp_req_check #(
    parameter int unsigned FUSE_WORDS = 4096,
    parameter int unsigned OFFS_W     = 16,
    parameter int unsigned LEN_W      = 16,
    parameter int unsigned AW         = 12,
    parameter int unsigned CW         = 13
) (
    input  logic [OFFS_W-1:0] offset,
    input  logic [LEN_W-1:0]  len,
    output logic              ok,
    output logic [AW-1:0]     start_idx,
    output logic [CW-1:0]     words
);
    localparam int unsigned SW = ((OFFS_W > LEN_W) ? OFFS_W : LEN_W) + 1;

    logic [SW-1:0] start_w;
    logic [SW-1:0] cnt_w;
    logic [SW-1:0] end_w;
    logic          aligned;
    logic          in_range;

    always_comb begin
        aligned   = (offset[1:0] == 2'b00) && (len[1:0] == 2'b00);
        start_w   = SW'(offset >> otp_rd_pkg::BYTE_SHIFT);
        cnt_w     = SW'(len >> otp_rd_pkg::BYTE_SHIFT);
        end_w     = start_w + cnt_w;
        in_range  = (start_w < SW'(FUSE_WORDS)) && (end_w <= SW'(FUSE_WORDS));
        ok        = aligned && in_range;
        start_idx = AW'(start_w);
        words     = CW'(cnt_w);
    end

endmodule

// File: rtl/otp_phase_timer.sv
module otp_phase_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] load,
    output logic          expired
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = load - TW'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    a_r4_timer_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        start && (load > TW'(1)) |=> !expired);

endmodule

// File: rtl/otp_read_seq.sv
module otp_read_seq #(
    parameter int unsigned FUSE_WORDS  = 4096,
    parameter int unsigned OFFS_W      = 16,
    parameter int unsigned LEN_W       = 16,
    parameter int unsigned CLK_MHZ     = 125,
    parameter int unsigned T_ACCESS_NS = 40000,
    parameter int unsigned T_LOW_NS    = 10000,
    parameter int unsigned T_STEP_NS   = 1000,
    localparam int unsigned AW = (FUSE_WORDS > 1) ? $clog2(FUSE_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [OFFS_W-1:0] req_offset,
    input  logic [LEN_W-1:0]  req_len,
    output logic              err,
    output logic              busy,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_data,
    output logic              otp_stby_n,
    output logic              otp_trim_en,
    output logic              otp_ce,
    output logic              otp_clk,
    output logic [AW-1:0]     otp_addr,
    input  logic [31:0]       otp_rdata
);
    import otp_rd_pkg::*;

    localparam int unsigned CW      = $clog2(FUSE_WORDS + 1);
    localparam int unsigned ACC_CYC = ns_to_cyc(T_ACCESS_NS, CLK_MHZ);
    localparam int unsigned LOW_CYC = ns_to_cyc(T_LOW_NS, CLK_MHZ);
    localparam int unsigned STP_CYC = ns_to_cyc(T_STEP_NS, CLK_MHZ);
    localparam int unsigned MAX_A   = (ACC_CYC > LOW_CYC) ? ACC_CYC : LOW_CYC;
    localparam int unsigned MAX_CYC = (MAX_A > STP_CYC) ? MAX_A : STP_CYC;
    localparam int unsigned TW      = $clog2(MAX_CYC + 1);

    typedef struct packed {
        seq_state_e            state;
        logic [AW-1:0]         addr;
        logic [CW-1:0]         left;
        logic [WORD_BITS-1:0]  data;
        logic                  err;
    } seq_regs_t;

    seq_regs_t     r_d, r_q;
    logic          chk_ok;
    logic [AW-1:0] chk_start;
    logic [CW-1:0] chk_words;
    logic          tmr_start;
    logic [TW-1:0] tmr_load;
    logic          tmr_done;

    otp_req_check #(
        .FUSE_WORDS (FUSE_WORDS),
        .OFFS_W     (OFFS_W),
        .LEN_W      (LEN_W),
        .AW         (AW),
        .CW         (CW)
    ) u_check (
        .offset    (req_offset),
        .len       (req_len),
        .ok        (chk_ok),
        .start_idx (chk_start),
        .words     (chk_words)
    );

    otp_phase_timer #(
        .TW (TW)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .load    (tmr_load),
        .expired (tmr_done)
    );

    always_comb begin
        r_d       = r_q;
        r_d.err   = 1'b0;
        tmr_start = 1'b0;
        tmr_load  = TW'(STP_CYC);
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (chk_ok) begin
                        r_d.state = ST_PU_STBY;
                        r_d.addr  = chk_start;
                        r_d.left  = chk_words;
                        tmr_start = 1'b1;
                    end else begin
                        r_d.err = 1'b1;
                    end
                end
            end
            ST_PU_STBY: if (tmr_done) begin
                r_d.state = ST_PU_TRIM;
                tmr_start = 1'b1;
            end
            ST_PU_TRIM: if (tmr_done) begin
                r_d.state = ST_PU_CE;
                tmr_start = 1'b1;
            end
            ST_PU_CE: if (tmr_done) begin
                tmr_start = 1'b1;
                if (r_q.left == '0) begin
                    r_d.state = ST_PD_CE;
                end else begin
                    r_d.state = ST_CLK_HI;
                    tmr_load  = TW'(ACC_CYC);
                end
            end
            ST_CLK_HI: if (tmr_done) begin
                r_d.state = ST_CLK_LO;
                tmr_start = 1'b1;
                tmr_load  = TW'(LOW_CYC);
            end
            ST_CLK_LO: if (tmr_done) begin
                r_d.state = ST_XFER;
                r_d.data  = otp_rdata;
            end
            ST_XFER: if (out_ready) begin
                r_d.left  = r_q.left - CW'(1);
                r_d.addr  = r_q.addr + AW'(1);
                tmr_start = 1'b1;
                if (r_q.left == CW'(1)) begin
                    r_d.state = ST_PD_CE;
                end else begin
                    r_d.state = ST_CLK_HI;
                    tmr_load  = TW'(ACC_CYC);
                end
            end
            ST_PD_CE: if (tmr_done) begin
                r_d.state = ST_PD_TRIM;
                tmr_start = 1'b1;
            end
            ST_PD_TRIM: if (tmr_done) begin
                r_d.state = ST_PD_STBY;
                tmr_start = 1'b1;
            end
            ST_PD_STBY: if (tmr_done) begin
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.addr  <= '0;
            r_q.left  <= '0;
            r_q.data  <= '0;
            r_q.err   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    // pin decode from the registered state
    always_comb begin
        otp_stby_n  = 1'b0;
        otp_trim_en = 1'b0;
        otp_ce      = 1'b0;
        otp_clk     = 1'b0;
        unique case (r_q.state)
            ST_IDLE: ;
            ST_PU_STBY: otp_stby_n = 1'b1;
            ST_PU_TRIM: begin
                otp_stby_n  = 1'b1;
                otp_trim_en = 1'b1;
            end
            ST_PU_CE, ST_CLK_LO, ST_XFER: begin
                otp_stby_n  = 1'b1;
                otp_trim_en = 1'b1;
                otp_ce      = 1'b1;
            end
            ST_CLK_HI: begin
                otp_stby_n  = 1'b1;
                otp_trim_en = 1'b1;
                otp_ce      = 1'b1;
                otp_clk     = 1'b1;
            end
            ST_PD_CE: begin
                otp_stby_n  = 1'b1;
                otp_trim_en = 1'b1;
            end
            ST_PD_TRIM: otp_stby_n = 1'b1;
            ST_PD_STBY: ;
            default: ;
        endcase
    end

    assign otp_addr  = r_q.addr;
    assign out_data  = r_q.data;
    assign out_valid = (r_q.state == ST_XFER);
    assign busy      = (r_q.state != ST_IDLE);
    assign req_ready = (r_q.state == ST_IDLE);
    assign err       = r_q.err;

    a_r10_clk_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
        otp_clk |-> otp_ce);
    a_r10_ce_needs_trim: assert property (@(posedge clk) disable iff (!rst_n)
        otp_ce |-> (otp_trim_en && otp_stby_n));
    a_r1_refuse_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !chk_ok |=> err && !busy && !otp_stby_n);
    a_r3_accept_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && chk_ok |=> busy && otp_stby_n && !err);
    a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        otp_clk && $past(otp_clk) |-> $stable(otp_addr));
    a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    a_r6_clk_low_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !otp_clk);
    a_r8_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);
    a_r8_no_err_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> !err);

endmodule

// File: tb/sim_otp_read_seq.sv
module sim_otp_read_seq;
    localparam int WORDS = 16;
    localparam int AWB   = 4;
    localparam int ACC   = 3;
    localparam int LOW   = 2;
    localparam int STEP  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_offset = '0;
    logic [7:0]  req_len = '0;
    logic        err, busy, out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        otp_stby_n, otp_trim_en, otp_ce, otp_clk;
    logic [AWB-1:0] otp_addr;
    logic [31:0] otp_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int exp_addr = 0;
    int clk_rises = 0;
    bit mon_on = 1'b0;

    always #4 clk = ~clk;

    otp_read_seq #(
        .FUSE_WORDS (WORDS),
        .OFFS_W     (8),
        .LEN_W      (8),
        .CLK_MHZ    (125),
        .T_ACCESS_NS(24),
        .T_LOW_NS   (16),
        .T_STEP_NS  (16)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_offset(req_offset), .req_len(req_len),
        .err(err), .busy(busy),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .otp_stby_n(otp_stby_n), .otp_trim_en(otp_trim_en), .otp_ce(otp_ce),
        .otp_clk(otp_clk), .otp_addr(otp_addr), .otp_rdata(otp_rdata)
    );

    function automatic logic [31:0] fuse_word(input int i);
        return (32'h9E3779B9 * 32'(i + 1)) ^ 32'h00FF00FF;
    endfunction

    // fuse macro model
    always @(posedge otp_clk) begin
        if (otp_ce && otp_trim_en && otp_stby_n) otp_rdata <= fuse_word(int'(otp_addr));
        else                                      otp_rdata <= 32'hDEAD0000;
    end

    task automatic chk(input bit cond, input string tag, input longint act, input longint exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // pin monitor, sampled on falling edges
    logic p_stby = 0, p_trim = 0, p_ce = 0, p_clk = 0, p_busy = 0, p_valid = 0;
    logic [AWB-1:0] p_addr = '0;
    int t_stby, t_trim, t_ce, t_cef, t_trimf, t_stbyf;
    int hicnt = 0, locnt = 0;
    bit first_clk = 0;

    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            if ((otp_clk && !otp_ce) || (otp_ce && !otp_trim_en) || (otp_trim_en && !otp_stby_n))
                chk(0, "R10 pin nesting", {otp_clk, otp_ce, otp_trim_en, otp_stby_n}, 0);
            if (otp_clk) begin hicnt++; locnt = 0; end
            else locnt++;
            if (otp_stby_n && !p_stby) begin
                t_stby = cyc;
                chk(busy == 1'b1, "R3 busy with standby release", busy, 1);
            end
            if (otp_trim_en && !p_trim) begin
                t_trim = cyc;
                chk(cyc - t_stby == STEP, "R3 trim after standby", cyc - t_stby, STEP);
            end
            if (otp_ce && !p_ce) begin
                t_ce = cyc; first_clk = 1;
                chk(cyc - t_trim == STEP, "R3 ce after trim", cyc - t_trim, STEP);
            end
            if (otp_clk && !p_clk) begin
                clk_rises++;
                chk(int'(otp_addr) == exp_addr, "R4 address at pulse", otp_addr, exp_addr);
                if (first_clk) begin
                    chk(cyc - t_ce == STEP, "R3 first pulse after ce", cyc - t_ce, STEP);
                    first_clk = 0;
                end
            end
            if (otp_clk && p_clk && otp_addr != p_addr)
                chk(0, "R4 address moved while high", otp_addr, p_addr);
            if (!otp_clk && p_clk) begin
                chk(hicnt == ACC, "R4 high phase", hicnt, ACC);
                hicnt = 0;
            end
            if (out_valid && !p_valid)
                chk(locnt == LOW + 1, "R5 low phase before word", locnt - 1, LOW);
            if (out_valid && otp_clk) chk(0, "R6 clock high with word pending", 1, 0);
            if (!otp_ce && p_ce) t_cef = cyc;
            if (!otp_trim_en && p_trim) begin
                t_trimf = cyc;
                chk(cyc - t_cef == STEP, "R7 trim off after ce off", cyc - t_cef, STEP);
            end
            if (!otp_stby_n && p_stby) begin
                t_stbyf = cyc;
                chk(cyc - t_trimf == STEP, "R7 standby after trim off", cyc - t_trimf, STEP);
            end
            if (!busy && p_busy)
                chk(cyc - t_stbyf == STEP, "R7 busy drop after standby", cyc - t_stbyf, STEP);
        end
        p_stby = otp_stby_n; p_trim = otp_trim_en; p_ce = otp_ce;
        p_clk = otp_clk; p_busy = busy; p_valid = out_valid; p_addr = otp_addr;
    end

    task automatic run_req(input int off, input int len, input bit good, input int stall, input bit poke);
        int n;
        int rises0;
        int extra;
        logic [31:0] held;
        n = len / 4;
        rises0 = clk_rises;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_offset = 8'(off); req_len = 8'(len);
        exp_addr = off / 4;
        @(negedge clk);
        req_valid = 1'b0;
        if (!good) begin
            chk(err == 1'b1, "R1/R2 err pulse", err, 1);
            chk(busy == 1'b0, "R1/R2 stays idle", busy, 0);
            @(negedge clk);
            chk(err == 1'b0, "R1 single err cycle", err, 0);
            repeat (3) @(negedge clk);
            chk(otp_stby_n == 1'b0 && clk_rises == rises0, "R2 no macro activity", otp_stby_n, 0);
            return;
        end
        chk(err == 1'b0 && busy == 1'b1, "R3 accepted", {err, busy}, 1);
        if (poke) begin
            req_valid = 1'b1; req_offset = 8'd1; req_len = 8'd4;
        end
        for (int k = 0; k < n; k++) begin
            int guard = 0;
            while (!out_valid && guard < 1000) begin
                @(negedge clk); guard++;
                if (poke) chk(err == 1'b0 && req_ready == 1'b0, "R8 ignored while busy", err, 0);
            end
            held = out_data;
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                chk(out_valid && out_data == held, "R6 hold during stall", out_data, held);
            end
            chk(out_data == fuse_word(exp_addr), "R5 word value", out_data, fuse_word(exp_addr));
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
            exp_addr++;
        end
        if (poke) begin
            chk(err == 1'b0, "R8 no err while busy", err, 0);
            req_valid = 1'b0;
        end
        extra = 0;
        for (int g = 0; g < 1000 && busy; g++) begin
            @(negedge clk);
            if (out_valid) extra++;
        end
        chk(extra == 0, "R6 word count", extra, 0);
        chk(req_ready == 1'b1 && busy == 1'b0, "R8 ready after done", req_ready, 1);
        if (n == 0) chk(clk_rises == rises0, "R9 no pulse for zero length", clk_rises - rises0, 0);
        chk(clk_rises - rises0 == n, "R4 one pulse per word", clk_rises - rises0, n);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && req_ready == 1 && err == 0 && out_valid == 0, "reset outputs", {busy, req_ready, err, out_valid}, 4'b0100);
        chk({otp_stby_n, otp_trim_en, otp_ce, otp_clk} == 4'b0000, "reset pins", {otp_stby_n, otp_trim_en, otp_ce, otp_clk}, 0);
        mon_on = 1'b1;
        // full sweep of legal runs
        for (int s = 0; s < WORDS; s++)
            for (int n = 0; n <= WORDS - s; n++)
                run_req(s * 4, n * 4, 1'b1, (s + n) % 3, 1'b0);
        // alignment refusals (R1)
        run_req(1, 4, 1'b0, 0, 1'b0);
        run_req(2, 4, 1'b0, 0, 1'b0);
        run_req(7, 8, 1'b0, 0, 1'b0);
        run_req(0, 1, 1'b0, 0, 1'b0);
        run_req(8, 6, 1'b0, 0, 1'b0);
        run_req(4, 3, 1'b0, 0, 1'b0);
        // range refusals (R2)
        run_req(64, 0, 1'b0, 0, 1'b0);
        run_req(68, 4, 1'b0, 0, 1'b0);
        run_req(252, 4, 1'b0, 0, 1'b0);
        run_req(60, 8, 1'b0, 0, 1'b0);
        run_req(0, 68, 1'b0, 0, 1'b0);
        run_req(32, 36, 1'b0, 0, 1'b0);
        // request held while busy (R8)
        run_req(8, 12, 1'b1, 1, 1'b1);
        // long stall (R6)
        run_req(20, 8, 1'b1, 9, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule